// File: doc/BRIEF.md
# Framebuffer Control Register Interface

This block is the register side of an indexed-colour framebuffer controller. A 32-bit register bus with a 21-bit byte address reaches its state. That state comprises a 256-entry colour lookup table, a three-entry cursor colour table, a 512-word cursor bitmap, and a set of scalar display registers. The scalar registers hold the visible width, the visible height, a control word, the byte offset of the first visible pixel in video memory, and the cursor coordinates.

The block decodes the stored state into forms a display engine can use directly:
- width and height in pixels;
- blank and cursor-disable flags;
- bits per pixel;
- the cursor X/Y coordinates;
- combinational lookup ports into the three tables.

The display engine pulses `frame_done` at the end of each frame, which raises `irq`. Any bus write lowers it again. A write to a dedicated address resets all register state. Writes to the video timing registers are accepted and have no effect.

Top module: `fbctl_regs`

## Requirements
- R1: A write to byte address 0x800 + 8*i (i = 0..255) stores colour entry i as red = wdata[23:16], green = wdata[15:8], blue = wdata[7:0]. The entry appears at `pix_rgb` as {R,G,B} when `pix_index` = i. Reads in this range return zero.
- R2: Writes to 0x508, 0x510 and 0x518 store cursor colour entries 0, 1 and 2 with the same RGB packing. A read at these addresses returns {8'h00,R,G,B}. The entry appears at `cpal_rgb` for `cpal_sel` 0..2, and `cpal_sel` = 3 gives zero.
- R3: A write to 0x1000 + 8*i (+0 or +4, i = 0..511) stores wdata[15:0] as cursor bitmap word i. A read at the same address returns the word zero-extended. The word appears at `cpat_word` when `cpat_index` = i.
- R4: A write of v to 0x118 sets `width_px` to 4*v[11:0]. A read of 0x118 returns v[11:0] zero-extended.
- R5: A write of v to 0x150 sets `height_px` to v[12:1], which is v/2 truncated. A read of 0x150 returns 2*`height_px`.
- R6: The control word at 0x300 is stored in full and reads back unchanged. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`.
- R7: Control bits [22:20] select `depth_bpp`. Codes 0 to 5 give 1, 2, 4, 8, 15 and 16, and codes 6 and 7 give 0.
- R8: A write of v to 0x400 sets `top_offset` to v[23:0]. A write of v to 0x638 sets `cur_x` to v[23:12] and `cur_y` to v[11:0]. Neither address is readable; reads there return zero.
- R9: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no output and no readable state.
- R10: A write to 0x100000 clears all three tables, the width, the height, the control word, the top offset and the cursor position. It also lowers `irq`.
- R11: A cycle with `frame_done` high raises `irq` on the next edge. Every accepted write, at any address, lowers it on the next edge and wins over a simultaneous `frame_done`. Otherwise `irq` holds.
- R12: `bus_ready` is always high. A read accepted on one edge gives `rsp_valid` high for exactly the following cycle, with `rsp_rdata` valid in that cycle. Reads of unmapped addresses return zero.
- R13: After the asynchronous reset, the following all read zero:
  - every table entry;
  - the width, height, control word, top offset and cursor position;
  - `irq` and `rsp_valid`.

  `depth_bpp` is therefore 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Byte address, 4-byte aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Always high |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| frame_done | input | 1 | End-of-frame pulse from the display engine |
| irq | output | 1 | Level refresh interrupt |
| pix_index | input | 8 | Colour table lookup index |
| pix_rgb | output | 24 | Colour table entry {R,G,B} |
| cpal_sel | input | 2 | Cursor colour lookup index |
| cpal_rgb | output | 24 | Cursor colour entry {R,G,B} |
| cpat_index | input | 9 | Cursor bitmap lookup index |
| cpat_word | output | 16 | Cursor bitmap word |
| width_px | output | 14 | Visible width in pixels |
| height_px | output | 12 | Visible height in lines |
| top_offset | output | 24 | Byte offset of the first visible pixel |
| cur_x | output | 12 | Cursor X coordinate |
| cur_y | output | 12 | Cursor Y coordinate |
| force_blank | output | 1 | Blank the display |
| cursor_off | output | 1 | Cursor disabled |
| depth_bpp | output | 5 | Decoded bits per pixel |

## Verification
The assertions check the following on every cycle:
- the interrupt's set, clear and hold rules, including write priority over the frame pulse;
- the one-cycle read response and the constant ready;
- that `depth_bpp` stays within its legal set;
- that a timing-register write leaves every scalar output stable;
- that the soft reset zeroes the scalar outputs.

Only the bench scenarios can show the following:
- the scaling of the width and height encodings and the lossy height read-back;
- the packing of RGB data into the tables;
- the index arithmetic of the three tables;
- that the soft reset also empties the tables;
- that palette, top-offset and cursor-position reads return zero.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  localparam int ADDR_W = 21;

  localparam logic [ADDR_W-1:0] A_CLUT_LO  = 21'h000800;
  localparam logic [ADDR_W-1:0] A_CLUT_HI  = 21'h001000;
  localparam logic [ADDR_W-1:0] A_CPAT_LO  = 21'h001000;
  localparam logic [ADDR_W-1:0] A_CPAT_HI  = 21'h002000;
  localparam logic [ADDR_W-1:0] A_CPAL_LO  = 21'h000508;
  localparam logic [ADDR_W-1:0] A_CPAL_HI  = 21'h000520;
  localparam logic [ADDR_W-1:0] A_WIDTH    = 21'h000118;
  localparam logic [ADDR_W-1:0] A_HEIGHT   = 21'h000150;
  localparam logic [ADDR_W-1:0] A_CTRL     = 21'h000300;
  localparam logic [ADDR_W-1:0] A_TOP      = 21'h000400;
  localparam logic [ADDR_W-1:0] A_CPOS     = 21'h000638;
  localparam logic [ADDR_W-1:0] A_SRESET   = 21'h100000;

  localparam int CTRL_BLANK_BIT = 10;
  localparam int CTRL_NOCUR_BIT = 23;
  localparam int CTRL_DEPTH_LSB = 20;

  typedef enum logic [3:0] {
    RG_NONE, RG_CLUT, RG_CPAL, RG_CPAT, RG_WIDTH, RG_HEIGHT,
    RG_CTRL, RG_TOP, RG_CPOS, RG_TIMING, RG_SRESET
  } region_e;

  function automatic logic is_timing(input logic [ADDR_W-1:0] a);
    case (a)
      21'h000000, 21'h000108, 21'h000110, 21'h000120, 21'h000128,
      21'h000130, 21'h000138, 21'h000140, 21'h000148, 21'h000158,
      21'h000160, 21'h000168, 21'h000170, 21'h000200: is_timing = 1'b1;
      default: is_timing = 1'b0;
    endcase
  endfunction

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0: depth_of = 5'd1;
      3'd1: depth_of = 5'd2;
      3'd2: depth_of = 5'd4;
      3'd3: depth_of = 5'd8;
      3'd4: depth_of = 5'd15;
      3'd5: depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [8:0]        index
);

  always_comb begin
    region = RG_NONE;
    index  = '0;
    if (addr >= A_CPAT_LO && addr < A_CPAT_HI) begin
      region = RG_CPAT;
      index  = addr[11:3];
    end else if (addr >= A_CLUT_LO && addr < A_CLUT_HI) begin
      region = RG_CLUT;
      index  = {1'b0, addr[10:3]};
    end else if (addr >= A_CPAL_LO && addr < A_CPAL_HI) begin
      region = RG_CPAL;
      index  = 9'((addr[4:0] - 5'd8) >> 3);
    end else begin
      case (addr)
        A_WIDTH:  region = RG_WIDTH;
        A_HEIGHT: region = RG_HEIGHT;
        A_CTRL:   region = RG_CTRL;
        A_TOP:    region = RG_TOP;
        A_CPOS:   region = RG_CPOS;
        A_SRESET: region = RG_SRESET;
        default:  region = is_timing(addr) ? RG_TIMING : RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fbctl_lut.sv
module fbctl_lut #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          hit;
    logic          en;
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb begin
      hit = we && (waddr == AW'(g));
      en  = clr || hit;
      d   = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign ent[g] = q;
  end

  if ((1 << AW) == DEPTH) begin : g_full
    assign rdata_a = ent[raddr_a];
    assign rdata_b = ent[raddr_b];
  end else begin : g_part
    assign rdata_a = (32'(raddr_a) < DEPTH) ? ent[raddr_a] : '0;
    assign rdata_b = (32'(raddr_b) < DEPTH) ? ent[raddr_b] : '0;
  end

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int WID_FIELD_W = 12,
  parameter int HGT_FIELD_W = 12,
  parameter int TOP_W       = 24,
  parameter int COORD_W     = 12,
  localparam int CLUT_DEPTH = 256,
  localparam int CPAT_DEPTH = 512,
  localparam int CPAL_DEPTH = 3,
  localparam int CLUT_AW    = $clog2(CLUT_DEPTH),
  localparam int CPAT_AW    = $clog2(CPAT_DEPTH),
  localparam int CPAL_AW    = $clog2(CPAL_DEPTH),
  localparam int CPOS_W     = 2 * COORD_W,
  localparam int WPX_W      = WID_FIELD_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic                   bus_ready,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  input  logic                   frame_done,
  output logic                   irq,
  input  logic [CLUT_AW-1:0]     pix_index,
  output logic [23:0]            pix_rgb,
  input  logic [CPAL_AW-1:0]     cpal_sel,
  output logic [23:0]            cpal_rgb,
  input  logic [CPAT_AW-1:0]     cpat_index,
  output logic [15:0]            cpat_word,
  output logic [WPX_W-1:0]       width_px,
  output logic [HGT_FIELD_W-1:0] height_px,
  output logic [TOP_W-1:0]       top_offset,
  output logic [COORD_W-1:0]     cur_x,
  output logic [COORD_W-1:0]     cur_y,
  output logic                   force_blank,
  output logic                   cursor_off,
  output logic [4:0]             depth_bpp
);

  region_e    rg;
  logic [8:0] idx;

  fbctl_decode u_dec (.addr(bus_addr), .region(rg), .index(idx));

  logic wr_acc, rd_acc, sreset;
  assign wr_acc = bus_valid && bus_write;
  assign rd_acc = bus_valid && !bus_write;
  assign sreset = wr_acc && (rg == RG_SRESET);

  // table storage
  logic [23:0] cpal_bus;
  logic [15:0] cpat_bus;
  logic [23:0] clut_unused_b;

  fbctl_lut #(.DEPTH(CLUT_DEPTH), .DW(24)) u_clut (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .we(wr_acc && rg == RG_CLUT), .waddr(idx[CLUT_AW-1:0]),
    .wdata(bus_wdata[23:0]),
    .raddr_a(pix_index), .rdata_a(pix_rgb),
    .raddr_b(pix_index), .rdata_b(clut_unused_b)
  );

  fbctl_lut #(.DEPTH(CPAL_DEPTH), .DW(24)) u_cpal (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .we(wr_acc && rg == RG_CPAL), .waddr(idx[CPAL_AW-1:0]),
    .wdata(bus_wdata[23:0]),
    .raddr_a(cpal_sel), .rdata_a(cpal_rgb),
    .raddr_b(idx[CPAL_AW-1:0]), .rdata_b(cpal_bus)
  );

  fbctl_lut #(.DEPTH(CPAT_DEPTH), .DW(16)) u_cpat (
    .clk(clk), .rst_n(rst_n), .clr(sreset),
    .we(wr_acc && rg == RG_CPAT), .waddr(idx[CPAT_AW-1:0]),
    .wdata(bus_wdata[15:0]),
    .raddr_a(cpat_index), .rdata_a(cpat_word),
    .raddr_b(idx[CPAT_AW-1:0]), .rdata_b(cpat_bus)
  );

  // scalar registers
  logic [WID_FIELD_W-1:0] wid_q, wid_d;
  logic [HGT_FIELD_W-1:0] hgt_q, hgt_d;
  logic [31:0]            ctl_q, ctl_d;
  logic [TOP_W-1:0]       top_q, top_d;
  logic [CPOS_W-1:0]      pos_q, pos_d;
  logic                   wid_en, hgt_en, ctl_en, top_en, pos_en;
  logic                   irq_q, irq_d;
  logic                   rsp_v_q;
  logic [31:0]            rdat_q, rdat_d;

  always_comb begin
    wid_en = sreset || (wr_acc && rg == RG_WIDTH);
    hgt_en = sreset || (wr_acc && rg == RG_HEIGHT);
    ctl_en = sreset || (wr_acc && rg == RG_CTRL);
    top_en = sreset || (wr_acc && rg == RG_TOP);
    pos_en = sreset || (wr_acc && rg == RG_CPOS);
    wid_d  = sreset ? '0 : bus_wdata[WID_FIELD_W-1:0];
    hgt_d  = sreset ? '0 : bus_wdata[HGT_FIELD_W:1];
    ctl_d  = sreset ? '0 : bus_wdata;
    top_d  = sreset ? '0 : bus_wdata[TOP_W-1:0];
    pos_d  = sreset ? '0 : bus_wdata[CPOS_W-1:0];
    // a write of any kind clears the interrupt and outranks the frame pulse
    if (wr_acc)          irq_d = 1'b0;
    else if (frame_done) irq_d = 1'b1;
    else                 irq_d = irq_q;
  end

  always_comb begin
    case (rg)
      RG_CPAT:   rdat_d = {16'h0, cpat_bus};
      RG_CPAL:   rdat_d = {8'h0, cpal_bus};
      RG_WIDTH:  rdat_d = 32'(wid_q);
      RG_HEIGHT: rdat_d = 32'({hgt_q, 1'b0});
      RG_CTRL:   rdat_d = ctl_q;
      default:   rdat_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q   <= '0;
      hgt_q   <= '0;
      ctl_q   <= '0;
      top_q   <= '0;
      pos_q   <= '0;
      irq_q   <= 1'b0;
      rsp_v_q <= 1'b0;
      rdat_q  <= '0;
    end else begin
      if (wid_en) wid_q  <= wid_d;
      if (hgt_en) hgt_q  <= hgt_d;
      if (ctl_en) ctl_q  <= ctl_d;
      if (top_en) top_q  <= top_d;
      if (pos_en) pos_q  <= pos_d;
      irq_q   <= irq_d;
      rsp_v_q <= rd_acc;
      if (rd_acc) rdat_q <= rdat_d;
    end
  end

  assign bus_ready   = 1'b1;
  assign rsp_valid   = rsp_v_q;
  assign rsp_rdata   = rdat_q;
  assign irq         = irq_q;
  assign width_px    = {wid_q, 2'b00};
  assign height_px   = hgt_q;
  assign top_offset  = top_q;
  assign cur_x       = pos_q[CPOS_W-1:COORD_W];
  assign cur_y       = pos_q[COORD_W-1:0];
  assign force_blank = ctl_q[CTRL_BLANK_BIT];
  assign cursor_off  = ctl_q[CTRL_NOCUR_BIT];
  assign depth_bpp   = depth_of(ctl_q[CTRL_DEPTH_LSB +: 3]);

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk
  import fbctl_pkg::*;
#(
  parameter int WID_FIELD_W = 12,
  parameter int HGT_FIELD_W = 12,
  parameter int TOP_W       = 24,
  parameter int COORD_W     = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_ready,
  input logic                     rsp_valid,
  input logic                     frame_done,
  input logic                     irq,
  input logic [WID_FIELD_W+1:0]   width_px,
  input logic [HGT_FIELD_W-1:0]   height_px,
  input logic [TOP_W-1:0]         top_offset,
  input logic [COORD_W-1:0]       cur_x,
  input logic [COORD_W-1:0]       cur_y,
  input logic                     force_blank,
  input logic                     cursor_off,
  input logic [4:0]               depth_bpp
);

  logic wr, rd;
  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !irq);

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !wr) |=> irq);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !wr) |=> (irq == $past(irq)));

  p_rsp_on_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);

  p_depth_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth_bpp inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});

  p_timing_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && is_timing(bus_addr)) |=> ($stable(width_px) && $stable(height_px)
      && $stable(top_offset) && $stable(cur_x) && $stable(cur_y)
      && $stable(force_blank) && $stable(cursor_off) && $stable(depth_bpp)));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_SRESET) |=> (width_px == '0 && height_px == '0
      && top_offset == '0 && cur_x == '0 && cur_y == '0 && !force_blank
      && !cursor_off && depth_bpp == 5'd1 && !irq));

endmodule

bind fbctl_regs fbctl_regs_chk #(
  .WID_FIELD_W(WID_FIELD_W), .HGT_FIELD_W(HGT_FIELD_W),
  .TOP_W(TOP_W), .COORD_W(COORD_W)
) u_chk (.*);

// File: tb/sim_fbctl_regs.sv
module sim_fbctl_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, frame_done;
  logic [20:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [7:0]  pix_index;
  logic [23:0] pix_rgb, cpal_rgb;
  logic [1:0]  cpal_sel;
  logic [8:0]  cpat_index;
  logic [15:0] cpat_word;
  logic [13:0] width_px;
  logic [11:0] height_px, cur_x, cur_y;
  logic [23:0] top_offset;
  logic        force_blank, cursor_off;
  logic [4:0]  depth_bpp;

  always #10 clk = ~clk;

  fbctl_regs u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [23:0] m_clut [256];
  logic [23:0] m_cpal [3];
  logic [15:0] m_cpat [512];
  logic [11:0] m_wid, m_hgt;
  logic [31:0] m_ctl;
  logic [23:0] m_top, m_pos;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_depth(input logic [2:0] c);
    case (c)
      3'd0: return 5'd1;  3'd1: return 5'd2;  3'd2: return 5'd4;
      3'd3: return 5'd8;  3'd4: return 5'd15; 3'd5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [20:0] a);
    if (a >= 21'h1000 && a < 21'h2000) return {16'h0, m_cpat[(a - 21'h1000) >> 3]};
    if (a >= 21'h508 && a < 21'h520)   return {8'h0, m_cpal[(a - 21'h508) >> 3]};
    if (a == 21'h118) return {20'h0, m_wid};
    if (a == 21'h150) return {19'h0, m_hgt, 1'b0};
    if (a == 21'h300) return m_ctl;
    return 32'h0;
  endfunction

  task automatic mdl_clear();
    for (int i = 0; i < 256; i++) m_clut[i] = '0;
    for (int i = 0; i < 512; i++) m_cpat[i] = '0;
    for (int i = 0; i < 3; i++)   m_cpal[i] = '0;
    m_wid = '0; m_hgt = '0; m_ctl = '0; m_top = '0; m_pos = '0;
  endtask

  task automatic mdl_write(input logic [20:0] a, input logic [31:0] d);
    if (a >= 21'h1000 && a < 21'h2000)     m_cpat[(a - 21'h1000) >> 3] = d[15:0];
    else if (a >= 21'h800 && a < 21'h1000) m_clut[(a - 21'h800) >> 3] = d[23:0];
    else if (a >= 21'h508 && a < 21'h520)  m_cpal[(a - 21'h508) >> 3] = d[23:0];
    else if (a == 21'h118) m_wid = d[11:0];
    else if (a == 21'h150) m_hgt = d[12:1];
    else if (a == 21'h300) m_ctl = d;
    else if (a == 21'h400) m_top = d[23:0];
    else if (a == 21'h638) m_pos = d[23:0];
    else if (a == 21'h100000) mdl_clear();
  endtask

  task automatic wr(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    mdl_write(a, d);
  endtask

  task automatic rd(input logic [20:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    chk("R12 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [20:0] a);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp_read(a));
  endtask

  task automatic chk_scalars(input string req);
    chk({req, " R4 width"},  32'(width_px),  32'({m_wid, 2'b00}));
    chk({req, " R5 height"}, 32'(height_px), 32'(m_hgt));
    chk({req, " R8 top"},    32'(top_offset), 32'(m_top));
    chk({req, " R8 curpos"}, {8'h0, cur_x, cur_y}, {8'h0, m_pos});
    chk({req, " R6 flags"},  {30'h0, force_blank, cursor_off}, {30'h0, m_ctl[10], m_ctl[23]});
    chk({req, " R7 depth"},  32'(depth_bpp), 32'(exp_depth(m_ctl[22:20])));
  endtask

  task automatic chk_luts(input string req, input int i);
    pix_index = 8'(i); cpat_index = 9'(i * 3 + 1); cpal_sel = 2'(i % 3);
    #1;
    chk({req, " R1 clut"}, 32'(pix_rgb), 32'(m_clut[8'(i)]));
    chk({req, " R3 cpat"}, 32'(cpat_word), 32'(m_cpat[9'(i * 3 + 1)]));
    chk({req, " R2 cpal"}, 32'(cpal_rgb), 32'(m_cpal[i % 3]));
  endtask

  task automatic frame_pulse(input bit with_write);
    @(negedge clk);
    frame_done = 1;
    if (with_write) begin bus_valid = 1; bus_write = 1; bus_addr = 21'h2000; bus_wdata = 32'h0; end
    @(negedge clk);
    frame_done = 0; bus_valid = 0; bus_write = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  localparam logic [20:0] TIMING_A [14] = '{21'h000, 21'h108, 21'h110, 21'h120,
    21'h128, 21'h130, 21'h138, 21'h140, 21'h148, 21'h158, 21'h160, 21'h168,
    21'h170, 21'h200};

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    frame_done = 0; pix_index = '0; cpal_sel = '0; cpat_index = '0;
    mdl_clear();
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 irq", {31'h0, irq}, 32'h0);
    chk("R13 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R13 depth", 32'(depth_bpp), 32'd1);
    chk("R12 ready", {31'h0, bus_ready}, 32'h1);
    chk_scalars("R13");
    chk_luts("R13", 5);

    // directed R4/R5 scaling
    wr(21'h118, 32'd320);
    chk("R4 width 320", 32'(width_px), 32'd1280);
    rd_chk("R4 readback", 21'h118);
    wr(21'h150, 32'd1025);
    chk("R5 height odd", 32'(height_px), 32'd512);
    rd_chk("R5 readback lossy", 21'h150);

    // R7 all codes
    for (int c = 0; c < 8; c++) begin
      wr(21'h300, (32'(c) << 20) | 32'h0080_0400);
      chk("R7 depth code", 32'(depth_bpp), 32'(exp_depth(3'(c))));
      chk("R6 blank/nocursor", {30'h0, force_blank, cursor_off}, 32'h3);
    end
    rd_chk("R6 ctrl readback", 21'h300);

    // R2 edges including sel 3
    wr(21'h508, 32'hFF11_2233);
    wr(21'h518, 32'h00AA_BBCC);
    rd_chk("R2 cpal0 read", 21'h508);
    rd_chk("R2 cpal2 read", 21'h518);
    cpal_sel = 2'd3; #1;
    chk("R2 sel3 zero", 32'(cpal_rgb), 32'h0);

    // R1 edges, palette not readable
    wr(21'h800, 32'h0012_3456);
    wr(21'hFF8, 32'hAB65_4321);
    pix_index = 8'd255; #1;
    chk("R1 clut 255", 32'(pix_rgb), 32'h654321);
    rd_chk("R1 clut unreadable", 21'h800);

    // R8 top / cursor position
    wr(21'h400, 32'h0012_3400);
    wr(21'h638, 32'h0040_2030);
    chk_scalars("R8");
    rd_chk("R8 top unreadable", 21'h400);
    rd_chk("R8 cpos unreadable", 21'h638);
    rd_chk("R12 unmapped", 21'h2000);

    // R3 last word, +4 alias
    wr(21'h1FFC, 32'hDEAD_BEEF);
    rd_chk("R3 last word", 21'h1FF8);

    // R9 timing writes ignored
    for (int i = 0; i < 14; i++) begin
      wr(TIMING_A[i], 32'hFFFF_FFFF);
      chk_scalars("R9");
      rd_chk("R9 read zero", TIMING_A[i]);
    end
    rd_chk("R9 ctrl intact", 21'h300);

    // R11 interrupt
    frame_pulse(0);
    chk("R11 set", {31'h0, irq}, 32'h1);
    rd(21'h300, v);
    chk("R11 read keeps irq", {31'h0, irq}, 32'h1);
    wr(21'h108, 32'h0);
    chk("R11 write clears", {31'h0, irq}, 32'h0);
    frame_pulse(1);
    chk("R11 clear wins", {31'h0, irq}, 32'h0);
    frame_pulse(0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: wr(21'h800 + 21'($urandom_range(0, 255)) * 8, $urandom);
        1: wr(21'h508 + 21'($urandom_range(0, 2)) * 8 + 21'($urandom_range(0, 1)) * 4, $urandom);
        2: wr(21'h1000 + 21'($urandom_range(0, 511)) * 8 + 21'($urandom_range(0, 1)) * 4, $urandom);
        3: wr(21'h118, $urandom);
        4: wr(21'h150, $urandom);
        5: wr(21'h300, $urandom);
        6: wr($urandom_range(0, 1) ? 21'h400 : 21'h638, $urandom);
        7: rd_chk("R3 rand read", 21'h1000 + 21'($urandom_range(0, 511)) * 8);
        8: rd_chk("R2 rand read", 21'h508 + 21'($urandom_range(0, 2)) * 8);
        default: rd_chk("R12 rand scalar read",
                   $urandom_range(0, 1) ? 21'h118 : ($urandom_range(0, 1) ? 21'h150 : 21'h300));
      endcase
      if (n % 20 == 0) begin
        chk_scalars("rand");
        chk_luts("rand", int'($urandom_range(0, 170)));
      end
    end

    // R10 soft reset
    frame_pulse(0);
    wr(21'h100000, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    chk_scalars("R10");
    for (int i = 0; i < 170; i += 13) chk_luts("R10", i);
    rd_chk("R10 cpal read", 21'h510);
    rd_chk("R10 ctrl read", 21'h300);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule